// File: doc/BRIEF.md
# Single-Cycle 32-bit Processor Core

This block is a small 32-bit processor that completes every instruction within one clock period. In each cycle it fetches the word that the program counter addresses, decodes the opcode into a set of control lines, reads two registers, computes in the ALU, optionally reads or writes data memory, and writes the result back. The next program counter is chosen in the same cycle. It can be the sequential address, a branch target or a jump target.

Instruction memory and data memory are two separate word arrays, so a fetch and a data access never compete for one port. Both arrays are inside the top module. While the core is held in reset, a shared preload port fills them. The current program counter is visible at the ports, and so is the data-memory write traffic: enable, byte address and data. Program results are therefore read by having the program store them.

Top module: `sc_core`

## Requirements
- R1: Reset is synchronous and active low. A rising edge with `rst_n` low sets the program counter to 0. While `rst_n` is low the core writes neither its registers nor data memory, and `st_en_o` stays low.
- R2: Every instruction that is not a taken branch or a jump advances the program counter by 4. `pc_o` is the byte address of the instruction executing in the current cycle. Fetch uses only PC bits [IAW+1:2]; higher bits wrap onto the instruction array.
- R3: Opcode 000000 is a register-register operation. Its result goes to the register in bits 15-11, and the operation is chosen by bits 5-0: 0x20 add, 0x22 subtract, 0x24 and, 0x25 or, 0x26 xor, 0x27 nor, 0x2A signed set-less-than, which yields 1 or 0.
- R4: Opcode 100011 loads the data word at byte address rs + sign-extended bits 15-0 into the register in bits 20-16. rs is bits 25-21, and the word index is address bits [DAW+1:2].
- R5: Opcode 101011 stores the register in bits 20-16 to byte address rs + sign-extended offset. In that same cycle `st_en_o` is high, `st_addr_o` carries the address and `st_data_o` the data. Memory is updated at the closing edge, and no register is written.
- R6: Opcode 000100 compares rs with rt. If they are equal, the next PC is PC+4 plus the sign-extended offset shifted left by 2, and negative offsets branch backwards. Otherwise the next PC is PC+4.
- R7: Opcode 000010 sets the next PC to bits 31-28 of PC+4, followed by instruction bits 25-0, followed by two zero bits.
- R8: Register 0 always reads as zero, and writes to it are discarded.
- R9: Any opcode not listed above writes no register and no memory, and advances the PC by 4.
- R10: An opcode-000000 instruction whose function field is not in the R3 list writes no register.
- R11: `st_en_o` is high only in cycles that execute a store.
- R12: While `load_en_i` is high, `load_data_i` is written at the rising edge into data memory if `load_dmem_i` is 1, or into instruction memory if it is 0. The write goes to word `load_addr_i` and takes priority over a core store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all state changes on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| load_en_i | input | 1 | Preload write strobe |
| load_dmem_i | input | 1 | Preload target: 1 data memory, 0 instruction memory |
| load_addr_i | input | LAW | Preload word index |
| load_data_i | input | XLEN | Preload word |
| pc_o | output | XLEN | Address of the instruction executing now |
| st_en_o | output | 1 | A store executes this cycle |
| st_addr_o | output | XLEN | Byte address of that store |
| st_data_o | output | XLEN | Word written by that store |

## Verification
On every cycle, assertions check several properties. The PC must be 0 after a reset edge and must advance by 4 after any instruction that does not redirect. A jump must land on its spliced target field. The branch compare must agree with the equality of the two source registers. The store strobe must appear only for the store opcode, a store of register 0 must carry zero, and unknown opcodes must raise no write enable. The scenarios alone show that arithmetic results are correct and that loads return previously written words. They also cover branch targets in both directions, the PC's upper bits taken from PC+4 when a jump crosses a 256 MB region, the discarding of writes to register 0 and of unknown function codes, and the preload path.

// File: rtl/sc_core_pkg.sv
// Package: shared opcodes, function codes, ALU selections and the
// control-word layout used by the decoder, the ALU and the top level.
package sc_core_pkg;

    localparam logic [5:0] OPC_REG  = 6'b000000;
    localparam logic [5:0] OPC_LOAD = 6'b100011;
    localparam logic [5:0] OPC_STOR = 6'b101011;
    localparam logic [5:0] OPC_BEQ  = 6'b000100;
    localparam logic [5:0] OPC_JMP  = 6'b000010;

    localparam logic [5:0] FC_ADD = 6'h20;
    localparam logic [5:0] FC_SUB = 6'h22;
    localparam logic [5:0] FC_AND = 6'h24;
    localparam logic [5:0] FC_OR  = 6'h25;
    localparam logic [5:0] FC_XOR = 6'h26;
    localparam logic [5:0] FC_NOR = 6'h27;
    localparam logic [5:0] FC_SLT = 6'h2A;

    // First-level ALU request from the main decoder.
    typedef enum logic [1:0] {
        AREQ_ADD   = 2'b00,
        AREQ_SUB   = 2'b01,
        AREQ_FIELD = 2'b10
    } alu_req_e;

    // Operation actually performed by the ALU.
    typedef enum logic [2:0] {
        AOP_AND = 3'd0,
        AOP_OR  = 3'd1,
        AOP_XOR = 3'd2,
        AOP_NOR = 3'd3,
        AOP_ADD = 3'd4,
        AOP_SUB = 3'd5,
        AOP_SLT = 3'd6
    } alu_op_e;

    typedef struct packed {
        logic     dst_is_rd;   // write target from bits 15-11 instead of 20-16
        logic     b_is_imm;    // ALU second operand is the extended immediate
        logic     wb_is_mem;   // write-back from data memory instead of ALU
        logic     reg_wr;      // register write enable
        logic     mem_rd;      // data memory read used this cycle
        logic     mem_wr;      // data memory write enable
        logic     is_branch;   // conditional branch on equality
        alu_req_e alu_req;     // first-level ALU request
        logic     is_jump;     // unconditional jump
    } ctrl_t;

endpackage

// File: rtl/sc_decode.sv
// Main decoder: turns the 6-bit opcode into the control word.
// Assumes: purely combinational, no state; unknown opcodes yield an
// all-quiet word (no writes, sequential PC).
module sc_decode
    import sc_core_pkg::*;
(
    input  logic [5:0] opcode_i,
    output ctrl_t      ctrl_o
);

    // Purpose: one control word per supported opcode, quiet default.
    always_comb begin
        ctrl_o         = '0;
        ctrl_o.alu_req = AREQ_ADD;
        case (opcode_i)
            OPC_REG: begin
                ctrl_o.dst_is_rd = 1'b1;
                ctrl_o.reg_wr    = 1'b1;
                ctrl_o.alu_req   = AREQ_FIELD;
            end
            OPC_LOAD: begin
                ctrl_o.b_is_imm  = 1'b1;
                ctrl_o.wb_is_mem = 1'b1;
                ctrl_o.reg_wr    = 1'b1;
                ctrl_o.mem_rd    = 1'b1;
            end
            OPC_STOR: begin
                ctrl_o.b_is_imm = 1'b1;
                ctrl_o.mem_wr   = 1'b1;
            end
            OPC_BEQ: begin
                ctrl_o.is_branch = 1'b1;
                ctrl_o.alu_req   = AREQ_SUB;
            end
            OPC_JMP: begin
                ctrl_o.is_jump = 1'b1;
            end
            default: ;
        endcase
    end

    // Purpose: R9 guard, an unlisted opcode must not enable any write.
    always_comb begin
        if (!(opcode_i inside {OPC_REG, OPC_LOAD, OPC_STOR, OPC_BEQ, OPC_JMP})) begin
            a_r9_unknown_quiet: assert (!ctrl_o.reg_wr && !ctrl_o.mem_wr && !ctrl_o.is_jump);
        end
    end

endmodule

// File: rtl/sc_alu.sv
// ALU with its second-level control: maps the decoder request plus the
// function field onto an operation and computes result and zero flag.
// Assumes: function field only matters for AREQ_FIELD; an unknown
// function code clears fn_ok_o and drives a zero result.
module sc_alu
    import sc_core_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  alu_req_e          req_i,
    input  logic [5:0]        funct_i,
    input  logic [XLEN-1:0]   a_i,
    input  logic [XLEN-1:0]   b_i,
    output logic [XLEN-1:0]   res_o,
    output logic              zero_o,
    output logic              fn_ok_o
);

    alu_op_e op;

    // Purpose: second-level decode of request and function field.
    always_comb begin
        op      = AOP_ADD;
        fn_ok_o = 1'b1;
        case (req_i)
            AREQ_ADD: op = AOP_ADD;
            AREQ_SUB: op = AOP_SUB;
            AREQ_FIELD: begin
                case (funct_i)
                    FC_ADD:  op = AOP_ADD;
                    FC_SUB:  op = AOP_SUB;
                    FC_AND:  op = AOP_AND;
                    FC_OR:   op = AOP_OR;
                    FC_XOR:  op = AOP_XOR;
                    FC_NOR:  op = AOP_NOR;
                    FC_SLT:  op = AOP_SLT;
                    default: fn_ok_o = 1'b0;
                endcase
            end
            default: fn_ok_o = 1'b0;
        endcase
    end

    // Purpose: the arithmetic and logic datapath itself.
    always_comb begin
        case (op)
            AOP_AND: res_o = a_i & b_i;
            AOP_OR:  res_o = a_i | b_i;
            AOP_XOR: res_o = a_i ^ b_i;
            AOP_NOR: res_o = ~(a_i | b_i);
            AOP_SUB: res_o = a_i - b_i;
            AOP_SLT: res_o = {{(XLEN-1){1'b0}}, ($signed(a_i) < $signed(b_i))};
            default: res_o = a_i + b_i;
        endcase
        if (!fn_ok_o) begin
            res_o = '0;
        end
    end

    assign zero_o = (res_o == '0);

    // Purpose: R3 guard, set-less-than produces only 0 or 1.
    always_comb begin
        if (op == AOP_SLT && fn_ok_o) begin
            a_r3_slt_boolean: assert (res_o[XLEN-1:1] == '0);
        end
    end

endmodule

// File: rtl/sc_regfile.sv
// Register file: two combinational read ports, one write port taken
// at the rising edge. Entry 0 is never written and always reads zero.
// Assumes: storage has no reset; software initialises what it reads.
module sc_regfile #(
    parameter  int XLEN = 32,
    parameter  int NREG = 32,
    localparam int RAW  = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            we_i,
    input  logic [RAW-1:0]  waddr_i,
    input  logic [XLEN-1:0] wdata_i,
    input  logic [RAW-1:0]  ra_a_i,
    input  logic [RAW-1:0]  ra_b_i,
    output logic [XLEN-1:0] rd_a_o,
    output logic [XLEN-1:0] rd_b_o
);

    logic [XLEN-1:0] regs [NREG];

    // Purpose: edge write, discarding any write aimed at entry 0.
    always_ff @(posedge clk) begin
        if (we_i && waddr_i != '0) begin
            regs[waddr_i] <= wdata_i;
        end
    end

    // Purpose: combinational reads with entry 0 forced to zero.
    always_comb begin
        rd_a_o = (ra_a_i == '0) ? '0 : regs[ra_a_i];
        rd_b_o = (ra_b_i == '0) ? '0 : regs[ra_b_i];
    end

endmodule

// File: rtl/sc_mem.sv
// Word memory used for both instruction and data storage: one write
// port taken at the rising edge, one combinational read port.
// Assumes: addresses are word indices already reduced to AW bits.
module sc_mem #(
    parameter  int XLEN  = 32,
    parameter  int WORDS = 64,
    localparam int AW    = $clog2(WORDS)
) (
    input  logic            clk,
    input  logic            we_i,
    input  logic [AW-1:0]   waddr_i,
    input  logic [XLEN-1:0] wdata_i,
    input  logic [AW-1:0]   raddr_i,
    output logic [XLEN-1:0] rdata_o
);

    logic [XLEN-1:0] cells [WORDS];

    // Purpose: write one word at the rising edge.
    always_ff @(posedge clk) begin
        if (we_i) begin
            cells[waddr_i] <= wdata_i;
        end
    end

    assign rdata_o = cells[raddr_i];

endmodule

// File: rtl/sc_core.sv
// Top level of the single-cycle core: program counter, instruction and
// data arrays, decoder, register file, ALU, write-back and next-PC
// selection. Assumes: the preload port is used while rst_n is low;
// the word formats are fixed at 32 bits with opcode in bits 31-26.
module sc_core
    import sc_core_pkg::*;
#(
    parameter  int XLEN       = 32,
    parameter  int NREG       = 32,
    parameter  int IMEM_WORDS = 64,
    parameter  int DMEM_WORDS = 64,
    localparam int IAW        = $clog2(IMEM_WORDS),
    localparam int DAW        = $clog2(DMEM_WORDS),
    localparam int LAW        = (IAW > DAW) ? IAW : DAW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load_en_i,
    input  logic            load_dmem_i,
    input  logic [LAW-1:0]  load_addr_i,
    input  logic [XLEN-1:0] load_data_i,
    output logic [XLEN-1:0] pc_o,
    output logic            st_en_o,
    output logic [XLEN-1:0] st_addr_o,
    output logic [XLEN-1:0] st_data_o
);

    localparam int RAW = $clog2(NREG);

    logic [XLEN-1:0] pc_q, pc_next, pc_seq, pc_br, pc_jmp;
    logic [XLEN-1:0] insn, imm_ext;
    logic [5:0]      opcode;
    logic [RAW-1:0]  f_rs, f_rt, f_rd, wr_sel;
    ctrl_t           ctl;
    logic [XLEN-1:0] rs_val, rt_val, alu_b, alu_res, wb_val;
    logic [XLEN-1:0] dmem_rdata, load_word;
    logic            alu_zero, fn_ok, take_br;
    logic            core_store, rf_we;
    logic            imem_load, dmem_load, dmem_we;
    logic [DAW-1:0]  dmem_waddr;
    logic [XLEN-1:0] dmem_wdata;
    logic            unused_shamt;

    // ---------------- fetch ----------------
    assign imem_load = load_en_i && !load_dmem_i;

    sc_mem #(.XLEN(XLEN), .WORDS(IMEM_WORDS)) u_imem (
        .clk     (clk),
        .we_i    (imem_load),
        .waddr_i (load_addr_i[IAW-1:0]),
        .wdata_i (load_data_i),
        .raddr_i (pc_q[IAW+1:2]),
        .rdata_o (insn)
    );

    // ---------------- decode ----------------
    assign opcode       = insn[31:26];
    assign f_rs         = insn[25:21];
    assign f_rt         = insn[20:16];
    assign f_rd         = insn[15:11];
    assign unused_shamt = ^insn[10:6];
    assign imm_ext      = {{(XLEN-16){insn[15]}}, insn[15:0]};

    sc_decode u_decode (
        .opcode_i (opcode),
        .ctrl_o   (ctl)
    );

    // ---------------- registers ----------------
    assign wr_sel = ctl.dst_is_rd ? f_rd : f_rt;
    assign rf_we  = rst_n && ctl.reg_wr && fn_ok;

    sc_regfile #(.XLEN(XLEN), .NREG(NREG)) u_regs (
        .clk     (clk),
        .we_i    (rf_we),
        .waddr_i (wr_sel),
        .wdata_i (wb_val),
        .ra_a_i  (f_rs),
        .ra_b_i  (f_rt),
        .rd_a_o  (rs_val),
        .rd_b_o  (rt_val)
    );

    // ---------------- execute ----------------
    assign alu_b = ctl.b_is_imm ? imm_ext : rt_val;

    sc_alu #(.XLEN(XLEN)) u_alu (
        .req_i   (ctl.alu_req),
        .funct_i (insn[5:0]),
        .a_i     (rs_val),
        .b_i     (alu_b),
        .res_o   (alu_res),
        .zero_o  (alu_zero),
        .fn_ok_o (fn_ok)
    );

    // ---------------- data memory ----------------
    assign core_store = rst_n && ctl.mem_wr;
    assign dmem_load  = load_en_i && load_dmem_i;
    assign dmem_we    = dmem_load || core_store;
    assign dmem_waddr = dmem_load ? load_addr_i[DAW-1:0] : alu_res[DAW+1:2];
    assign dmem_wdata = dmem_load ? load_data_i : rt_val;

    sc_mem #(.XLEN(XLEN), .WORDS(DMEM_WORDS)) u_dmem (
        .clk     (clk),
        .we_i    (dmem_we),
        .waddr_i (dmem_waddr),
        .wdata_i (dmem_wdata),
        .raddr_i (alu_res[DAW+1:2]),
        .rdata_o (dmem_rdata)
    );

    // ---------------- write-back ----------------
    assign load_word = ctl.mem_rd ? dmem_rdata : '0;
    assign wb_val    = ctl.wb_is_mem ? load_word : alu_res;

    // ---------------- next PC ----------------
    assign pc_seq  = pc_q + XLEN'(4);
    assign pc_br   = pc_seq + {imm_ext[XLEN-3:0], 2'b00};
    assign pc_jmp  = {pc_seq[XLEN-1:28], insn[25:0], 2'b00};
    assign take_br = ctl.is_branch && alu_zero;

    // Purpose: choose the address of the next instruction.
    always_comb begin
        if (ctl.is_jump) begin
            pc_next = pc_jmp;
        end else if (take_br) begin
            pc_next = pc_br;
        end else begin
            pc_next = pc_seq;
        end
    end

    // Purpose: program counter register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q <= '0;
        end else begin
            pc_q <= pc_next;
        end
    end

    // ---------------- outputs ----------------
    assign pc_o      = pc_q;
    assign st_en_o   = core_store;
    assign st_addr_o = alu_res;
    assign st_data_o = rt_val;

    // ---------------- assertions ----------------
    a_r1_pc_zero_after_reset: assert property (@(posedge clk)
        !rst_n |=> (pc_o == '0));

    a_r2_sequential_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl.is_jump && !take_br) |=> (pc_o == $past(pc_o) + XLEN'(4)));

    a_r6_compare_matches: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.is_branch |-> (alu_zero == (rs_val == rt_val)));

    a_r7_jump_field: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.is_jump |=> (pc_o[27:2] == $past(insn[25:0])));

    a_r8_store_of_zero_reg: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode == OPC_STOR && f_rt == '0) |-> (st_data_o == '0));

    a_r11_store_only_on_store: assert property (@(posedge clk) disable iff (!rst_n)
        st_en_o |-> (opcode == OPC_STOR));

endmodule

// File: tb/sc_core_bench.sv
module sc_core_bench;

    localparam int XLEN = 32;
    localparam int LAW  = 6;

    localparam logic [5:0] OP_LD = 6'b100011;
    localparam logic [5:0] OP_ST = 6'b101011;
    localparam logic [5:0] OP_BQ = 6'b000100;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            load_en;
    logic            load_dmem;
    logic [LAW-1:0]  load_addr;
    logic [XLEN-1:0] load_data;
    logic [XLEN-1:0] pc_o, st_addr_o, st_data_o;
    logic            st_en_o;

    int n_run  = 0;
    int n_fail = 0;

    logic [XLEN-1:0] log_a [32];
    logic [XLEN-1:0] log_d [32];
    int              log_n = 0;

    sc_core u_sc_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_en_i   (load_en),
        .load_dmem_i (load_dmem),
        .load_addr_i (load_addr),
        .load_data_i (load_data),
        .pc_o        (pc_o),
        .st_en_o     (st_en_o),
        .st_addr_o   (st_addr_o),
        .st_data_o   (st_data_o)
    );

    always #5 clk = ~clk;

    // Record every store seen mid-cycle while the core runs.
    always @(negedge clk) begin
        if (rst_n === 1'b1 && st_en_o === 1'b1 && log_n < 32) begin
            log_a[log_n] = st_addr_o;
            log_d[log_n] = st_data_o;
            log_n = log_n + 1;
        end
    end

    function automatic logic [31:0] enc_r(int rs, int rt, int rd, logic [5:0] fn);
        enc_r = {6'b000000, rs[4:0], rt[4:0], rd[4:0], 5'b00000, fn};
    endfunction

    function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, int imm);
        enc_i = {op, rs[4:0], rt[4:0], imm[15:0]};
    endfunction

    function automatic logic [31:0] enc_j(logic [25:0] tgt);
        enc_j = {6'b000010, tgt};
    endfunction

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_run = n_run + 1;
        if (act !== exp) begin
            n_fail = n_fail + 1;
            $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic ld(bit to_dmem, int addr, logic [31:0] data);
        load_en   = 1'b1;
        load_dmem = to_dmem;
        load_addr = addr[LAW-1:0];
        load_data = data;
        @(posedge clk);
        #1;
        load_en = 1'b0;
    endtask

    task automatic enter_reset();
        @(posedge clk);
        #1 rst_n = 1'b0;
        @(posedge clk);
        #1;
    endtask

    task automatic start_run();
        @(posedge clk);
        #2;
        log_n = 0;
        rst_n = 1'b1;
    endtask

    task automatic cycles(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_store(string req, int idx, logic [31:0] ea, logic [31:0] ed);
        check(req, $sformatf("store %0d addr", idx), log_a[idx], ea);
        check(req, $sformatf("store %0d data", idx), log_d[idx], ed);
    endtask

    // R1 R11 R12: reset holds PC and gates stores, mid-run reset returns to 0.
    task automatic t_reset();
        enter_reset();
        ld(0, 0, enc_i(OP_ST, 0, 0, 16'h10));
        ld(0, 1, enc_j(26'h1));
        @(negedge clk);
        check("R1", "pc in reset", pc_o, 32'h0);
        check("R1", "store gated in reset", {31'b0, st_en_o}, 32'h0);
        start_run();
        @(negedge clk);
        check("R5", "store strobe", {31'b0, st_en_o}, 32'h1);
        check("R5", "store address", st_addr_o, 32'h10);
        check("R8", "store data of reg 0", st_data_o, 32'h0);
        cycles(2);
        check("R7", "jump to self", pc_o, 32'h4);
        @(posedge clk);
        #1 rst_n = 1'b0;
        cycles(2);
        check("R1", "pc after mid-run reset", pc_o, 32'h0);
        check("R11", "no strobe in reset on store word", {31'b0, st_en_o}, 32'h0);
    endtask

    // R2 R3 R4 R5 R12: loads, every ALU function, stores and memory readback.
    task automatic t_arith();
        int p;
        enter_reset();
        ld(1, 0, 32'd7);
        ld(1, 1, 32'd3);
        ld(1, 2, 32'hFFFF_FFF0);
        p = 0;
        ld(0, p, enc_i(OP_LD, 0, 1, 0));       p++;
        ld(0, p, enc_i(OP_LD, 0, 2, 4));       p++;
        ld(0, p, enc_i(OP_LD, 0, 3, 8));       p++;
        ld(0, p, enc_r(1, 2, 4, 6'h20));       p++;
        ld(0, p, enc_r(1, 2, 5, 6'h22));       p++;
        ld(0, p, enc_r(1, 2, 6, 6'h24));       p++;
        ld(0, p, enc_r(1, 2, 7, 6'h25));       p++;
        ld(0, p, enc_r(1, 2, 8, 6'h26));       p++;
        ld(0, p, enc_r(1, 2, 9, 6'h27));       p++;
        ld(0, p, enc_r(3, 1, 10, 6'h2A));      p++;
        ld(0, p, enc_r(1, 3, 11, 6'h2A));      p++;
        for (int r = 4; r <= 11; r++) begin
            ld(0, p, enc_i(OP_ST, 0, r, 16 + 4 * (r - 4))); p++;
        end
        ld(0, p, enc_i(OP_ST, 5, 4, -4));      p++;
        ld(0, p, enc_i(OP_LD, 0, 13, 0));      p++;
        ld(0, p, enc_i(OP_ST, 0, 13, 16'h3C)); p++;
        ld(0, p, enc_j(26'h16));
        start_run();
        cycles(40);
        check("R5", "store count", log_n, 10);
        check_store("R3", 0, 32'd16, 32'd10);
        check_store("R3", 1, 32'd20, 32'd4);
        check_store("R3", 2, 32'd24, 32'd3);
        check_store("R3", 3, 32'd28, 32'd7);
        check_store("R3", 4, 32'd32, 32'd4);
        check_store("R3", 5, 32'd36, 32'hFFFF_FFF8);
        check_store("R3", 6, 32'd40, 32'd1);
        check_store("R3", 7, 32'd44, 32'd0);
        check_store("R5", 8, 32'd0, 32'd10);
        check_store("R4", 9, 32'd60, 32'd10);
        check("R2", "final pc", pc_o, 32'h58);
    endtask

    // R8 R9 R10: writes to reg 0, unknown function codes and unknown opcodes.
    task automatic t_ignored();
        enter_reset();
        ld(1, 0, 32'd7);
        ld(1, 1, 32'd3);
        ld(0, 0, enc_i(OP_LD, 0, 1, 0));
        ld(0, 1, enc_i(OP_LD, 0, 0, 4));
        ld(0, 2, enc_r(1, 1, 0, 6'h20));
        ld(0, 3, enc_i(OP_ST, 0, 0, 16'h30));
        ld(0, 4, enc_r(1, 0, 12, 6'h25));
        ld(0, 5, enc_r(1, 1, 12, 6'h3F));
        ld(0, 6, enc_i(6'b001000, 0, 12, 5));
        ld(0, 7, enc_i(6'b111111, 0, 1, 16'h40));
        ld(0, 8, enc_i(OP_ST, 0, 12, 16'h34));
        ld(0, 9, enc_j(26'h9));
        start_run();
        cycles(20);
        check("R9", "store count with unknown opcodes", log_n, 2);
        check_store("R8", 0, 32'd48, 32'd0);
        check_store("R10", 1, 32'd52, 32'd7);
        check("R9", "pc stepped past unknown opcodes", pc_o, 32'h24);
    endtask

    // R6: branch not taken, taken forward, taken backward.
    task automatic t_branch();
        enter_reset();
        ld(1, 0, 32'd7);
        ld(1, 1, 32'd7);
        ld(1, 2, 32'd3);
        ld(0, 0, enc_i(OP_LD, 0, 1, 0));
        ld(0, 1, enc_i(OP_LD, 0, 2, 4));
        ld(0, 2, enc_i(OP_LD, 0, 3, 8));
        ld(0, 3, enc_i(OP_BQ, 1, 3, 2));
        ld(0, 4, enc_i(OP_ST, 0, 1, 16'h40));
        ld(0, 5, enc_i(OP_BQ, 1, 2, 2));
        ld(0, 6, enc_i(OP_ST, 0, 3, 16'h44));
        ld(0, 7, enc_i(OP_ST, 0, 3, 16'h48));
        ld(0, 8, enc_i(OP_ST, 0, 2, 16'h4C));
        ld(0, 9, enc_i(OP_BQ, 0, 0, -1));
        start_run();
        cycles(20);
        check("R6", "stores around branches", log_n, 2);
        check_store("R6", 0, 32'h40, 32'd7);
        check_store("R6", 1, 32'h4C, 32'd7);
        check("R6", "backward loop pc", pc_o, 32'h24);
        @(negedge clk);
        check("R6", "backward loop holds", pc_o, 32'h24);
    endtask

    // R7 R2: jump splice, fetch wrap and upper bits taken from PC+4.
    task automatic t_jump();
        enter_reset();
        ld(0, 0, enc_j(26'h3FF_FFFC));
        ld(0, 60, enc_i(OP_ST, 0, 0, 16'h50));
        ld(0, 61, 32'h0);
        ld(0, 62, 32'h0);
        ld(0, 63, enc_j(26'h10));
        ld(0, 16, enc_j(26'h10));
        start_run();
        @(negedge clk);
        check("R2", "first fetch", pc_o, 32'h0);
        @(negedge clk);
        check("R7", "jump splice", pc_o, 32'h0FFF_FFF0);
        check("R2", "wrapped fetch stores", {31'b0, st_en_o}, 32'h1);
        cycles(3);
        check("R2", "sequential at top", pc_o, 32'h0FFF_FFFC);
        @(negedge clk);
        check("R7", "upper bits from pc+4", pc_o, 32'h1000_0040);
        @(negedge clk);
        check("R7", "jump self", pc_o, 32'h1000_0040);
        check("R5", "single store", log_n, 1);
        check_store("R5", 0, 32'h50, 32'h0);
    endtask

    initial begin
        rst_n     = 1'b0;
        load_en   = 1'b0;
        load_dmem = 1'b0;
        load_addr = '0;
        load_data = '0;
        #1;
        t_reset();
        t_arith();
        t_ignored();
        t_branch();
        t_jump();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #1_000_000;
        n_run  = n_run + 1;
        n_fail = n_fail + 1;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule